// File: doc/BRIEF.md
# Chopped ADC Result Postprocessor

This block takes the signed words coming out of a decimation filter and turns them into final conversion results. It can apply system chopping. The block drives a polarity line that asks the front end to swap the input on every other conversion, and it combines each pair of opposite-polarity words so that a constant offset cancels. It can also smooth the stream with a two-result running average. Finally, it can collapse a group of consecutive results into one output through a programmable averaging postfilter.

A single 16-bit control word selects the modes. The control word holds a chop enable, a running-average enable and a 6-bit averaging factor. Any write of the control word restarts the whole pipeline from an empty state. When chopping is on, the running average is always applied. With chop on and an averaging factor of zero, the block groups three results per output, so the output rate drops to one third. With a nonzero factor, the output rate depends only on the factor, whether chop is on or off.

Top module: `chop_post_proc`

## Requirements
- R1: After reset, `out_valid` and `chop_pol` are 0 and the configuration is chop off, running average off, factor 0. In this state every accepted word appears unchanged, sign-extended to DW+1 bits.
- R2: A control write decodes chop enable from bit 15, running-average enable from bit 14 and the averaging factor from bits 13:8. Bits 7:0 are ignored. The write clears the polarity, all history and the partial group.
- R3: With chop on, `chop_pol` inverts after every accepted word. A word accepted while `chop_pol` is 1 is negated before use. With chop off, `chop_pol` stays 0.
- R4: With chop on, each accepted word after the first since a clear yields a chopped value equal to floor((s_n + s_(n-1)) / 2), where s is the polarity-corrected word. The first word after a clear yields nothing.
- R5: When the running average is on, or chop is on, each stage value after the first since a clear yields floor((v_n + v_(n-1)) / 2). Otherwise values pass through unchanged.
- R6: The group size K is AF+1 when AF > 0, 3 when AF = 0 with chop on, and 1 otherwise. Each output equals the sum of K consecutive averaged values divided by K, truncated toward zero.
- R7: `out_valid` is high for the single cycle after the clock edge that accepted the word completing a group. It is never high in any other cycle.
- R8: After a control write, the first output follows K + c + a accepted words, where c is 1 if chop is on and a is 1 if the running average is in effect. After that, one output follows every K accepted words.
- R9: A word presented in the same cycle as a control write is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_data | input | 16 | Control word value |
| in_valid | input | 1 | Filter word valid |
| in_data | input | DW | Signed filter word |
| chop_pol | output | 1 | Input swap request for the next conversion |
| out_valid | output | 1 | One-cycle result strobe |
| out_data | output | DW+1 | Signed result |

## Verification
The bench sweeps every combination of chop and running-average enable against averaging factors 0, 1, 2, 5 and 63. The input words include both extremes of the input range. This hits three hazards. A design that negates the most negative word in DW bits would wrap it to itself. One that shifts toward zero instead of flooring would be off by one on odd negative sums. One that rounds the group quotient the wrong way would differ on negative remainders. Each new configuration is written in the middle of a running stream. A design that kept old history or a partial group across the write would produce its first output early or with a stale value. The bench also places a word in the same cycle as a write, and counts words to the first output to check the settling rule against the group-size rule.

// File: rtl/cpp_pkg.sv
package cpp_pkg;

  localparam int CTLW       = 16;
  localparam int AFW        = 6;
  localparam int CHOP_BIT   = 15;
  localparam int RAVG_BIT   = 14;
  localparam int AF_LSB     = 8;

  typedef struct packed {
    logic           chop;
    logic           ravg;
    logic [AFW-1:0] af;
  } ctl_t;

  function automatic ctl_t ctl_decode(input logic [CTLW-1:0] w);
    ctl_t c;
    c.chop = w[CHOP_BIT];
    c.ravg = w[RAVG_BIT];
    c.af   = w[AF_LSB +: AFW];
    return c;
  endfunction

endpackage

// File: rtl/cpp_chop_stage.sv
module cpp_chop_stage #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          chop,
  input  logic          acc,
  input  logic [DW-1:0] in_data,
  output logic          pol,
  output logic          c_valid,
  output logic [DW:0]   c_data
);

  localparam int SW = DW + 1;

  logic          have_q, have_d, pol_d;
  logic [SW-1:0] prev_q, prev_d;
  logic [SW-1:0] ext, s;
  logic [SW:0]   pair;
  logic          unused_pair_lsb;

  always_comb begin
    ext  = {in_data[DW-1], in_data};
    s    = pol ? (~ext + SW'(1)) : ext;
    pair = {s[SW-1], s} + {prev_q[SW-1], prev_q};
  end
  assign unused_pair_lsb = pair[0];

  always_comb begin
    c_valid = acc && (!chop || have_q);
    c_data  = chop ? pair[SW:1] : s;
  end

  always_comb begin
    pol_d  = pol;
    have_d = have_q;
    prev_d = prev_q;
    if (clr) begin
      pol_d  = 1'b0;
      have_d = 1'b0;
      prev_d = '0;
    end else if (acc && chop) begin
      pol_d  = ~pol;
      have_d = 1'b1;
      prev_d = s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol    <= 1'b0;
      have_q <= 1'b0;
      prev_q <= '0;
    end else begin
      pol    <= pol_d;
      have_q <= have_d;
      prev_q <= prev_d;
    end
  end

  p_pol_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(acc && chop && !clr) |-> (pol != $past(pol)));

  p_pol_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!acc) && $past(!clr)) |-> $stable(pol));

  p_pol_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr) |-> !pol);

endmodule

// File: rtl/cpp_pair_avg.sv
module cpp_pair_avg #(
  parameter int W = 17
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic         v_in,
  input  logic [W-1:0] d_in,
  output logic         v_out,
  output logic [W-1:0] d_out
);

  logic         have_q, have_d;
  logic [W-1:0] prev_q, prev_d;
  logic [W:0]   pair;
  logic         unused_pair_lsb;

  always_comb begin
    pair = {d_in[W-1], d_in} + {prev_q[W-1], prev_q};
  end
  assign unused_pair_lsb = pair[0];

  always_comb begin
    v_out = v_in && (!en || have_q);
    d_out = en ? pair[W:1] : d_in;
  end

  always_comb begin
    have_d = have_q;
    prev_d = prev_q;
    if (clr) begin
      have_d = 1'b0;
      prev_d = '0;
    end else if (v_in && en) begin
      have_d = 1'b1;
      prev_d = d_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_q <= 1'b0;
      prev_q <= '0;
    end else begin
      have_q <= have_d;
      prev_q <= prev_d;
    end
  end

  p_first_dropped_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr) |-> !have_q);

endmodule

// File: rtl/cpp_group_avg.sv
module cpp_group_avg #(
  parameter int DW  = 16,
  parameter int AFW = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           chop,
  input  logic [AFW-1:0] af,
  input  logic           r_valid,
  input  logic [DW:0]    r_data,
  output logic           out_valid,
  output logic [DW:0]    out_data
);

  localparam int RW   = DW + 1;
  localparam int KW   = AFW + 1;
  localparam int SUMW = RW + AFW;

  logic [KW-1:0]          k;
  logic [KW-1:0]          cnt_q, cnt_d;
  logic signed [SUMW-1:0] acc_q, acc_d, nsum, quot;
  logic                   last, fire_d;
  logic                   unused_quot_hi;

  always_comb begin
    if (af != '0)  k = KW'(af) + KW'(1);
    else if (chop) k = KW'(3);
    else           k = KW'(1);
  end

  always_comb begin
    nsum = acc_q + $signed({{AFW{r_data[RW-1]}}, r_data});
    quot = nsum / $signed({{(SUMW-KW){1'b0}}, k});
    last = (cnt_q == k - KW'(1));
  end
  assign unused_quot_hi = ^quot[SUMW-1:RW];

  always_comb begin
    cnt_d  = cnt_q;
    acc_d  = acc_q;
    fire_d = 1'b0;
    if (clr) begin
      cnt_d = '0;
      acc_d = '0;
    end else if (r_valid) begin
      if (last) begin
        cnt_d  = '0;
        acc_d  = '0;
        fire_d = 1'b1;
      end else begin
        cnt_d = cnt_q + KW'(1);
        acc_d = nsum;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      acc_q <= acc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= fire_d;
      if (fire_d) out_data <= quot[RW-1:0];
    end
  end

  p_cnt_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < k);

  p_group_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (cnt_q == '0));

endmodule

// File: rtl/chop_post_proc.sv
module chop_post_proc #(
  parameter int DW = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_wr,
  input  logic [cpp_pkg::CTLW-1:0]  cfg_data,
  input  logic                      in_valid,
  input  logic [DW-1:0]             in_data,
  output logic                      chop_pol,
  output logic                      out_valid,
  output logic [DW:0]               out_data
);

  import cpp_pkg::*;

  ctl_t         ctl_q, ctl_d;
  logic         acc, ravg_eff;
  logic         c_valid, r_valid;
  logic [DW:0]  c_data, r_data;
  logic         unused_cfg_lo;

  assign unused_cfg_lo = ^cfg_data[AF_LSB-1:0];

  always_comb begin
    ctl_d = cfg_wr ? ctl_decode(cfg_data) : ctl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_d;
  end

  assign acc      = in_valid && !cfg_wr;
  assign ravg_eff = ctl_q.ravg || ctl_q.chop;

  cpp_chop_stage #(.DW(DW)) u_chop (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (cfg_wr),
    .chop    (ctl_q.chop),
    .acc     (acc),
    .in_data (in_data),
    .pol     (chop_pol),
    .c_valid (c_valid),
    .c_data  (c_data)
  );

  cpp_pair_avg #(.W(DW + 1)) u_pair (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cfg_wr),
    .en    (ravg_eff),
    .v_in  (c_valid),
    .d_in  (c_data),
    .v_out (r_valid),
    .d_out (r_data)
  );

  cpp_group_avg #(.DW(DW), .AFW(AFW)) u_group (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (cfg_wr),
    .chop      (ctl_q.chop),
    .af        (ctl_q.af),
    .r_valid   (r_valid),
    .r_data    (r_data),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid && !cfg_wr));

  p_write_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_wr) |-> (!out_valid && !chop_pol));

  p_chop_third_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && ctl_q.chop && ctl_q.af == '0) |=> !out_valid);

endmodule

// File: tb/chop_post_proc_bench.sv
module chop_post_proc_bench;

  localparam int DW      = 16;
  localparam int CLK_PER = 10;
  localparam int WD_LIM  = 150000;

  logic          clk, rst_n, cfg_wr, in_valid;
  logic [15:0]   cfg_data;
  logic [DW-1:0] in_data;
  logic          chop_pol, out_valid;
  logic [DW:0]   out_data;

  int total, bad;

  chop_post_proc #(.DW(DW)) u_chop_post_proc (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
    .in_valid(in_valid), .in_data(in_data),
    .chop_pol(chop_pol), .out_valid(out_valid), .out_data(out_data)
  );

  initial clk = 1'b0;
  always #(CLK_PER/2) clk = ~clk;

  // reference model state
  bit    m_chop, m_ra, m_pol, m_hs, m_hc, m_fire, m_first;
  int    m_af, m_k, m_cnt, m_words;
  longint m_ps, m_pc, m_sum, m_q;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic m_clear(input logic [15:0] w);
    m_chop = w[15]; m_ra = w[14]; m_af = int'(w[13:8]);
    m_k = (m_af != 0) ? m_af + 1 : (m_chop ? 3 : 1);
    m_pol = 0; m_hs = 0; m_hc = 0; m_cnt = 0; m_sum = 0;
    m_ps = 0; m_pc = 0; m_words = 0; m_first = 1;
  endtask

  task automatic m_word(input longint x);
    longint s, c, r;
    bit cv, rv;
    s = m_pol ? -x : x;
    if (m_chop) begin
      cv = m_hs; c = (s + m_ps) >>> 1;
      m_hs = 1; m_ps = s; m_pol = ~m_pol;
    end else begin
      cv = 1; c = s;
    end
    rv = cv; r = c;
    if (cv && (m_ra || m_chop)) begin
      rv = m_hc; r = (c + m_pc) >>> 1;
      m_hc = 1; m_pc = c;
    end
    m_words++;
    if (rv) begin
      m_sum += r; m_cnt++;
      if (m_cnt == m_k) begin
        m_fire = 1; m_q = m_sum / m_k;
        m_sum = 0; m_cnt = 0;
      end
    end
  endtask

  string data_tag;

  // one clock: drive at negedge, compare at the next negedge
  task automatic step(input bit v, input longint x, input bit wr, input logic [15:0] w);
    cfg_wr = wr; cfg_data = w; in_valid = v; in_data = DW'(x);
    @(posedge clk);
    m_fire = 0;
    if (wr) m_clear(w);
    else if (v) m_word(x);
    @(negedge clk);
    cfg_wr = 0; in_valid = 0;
    check(out_valid == m_fire, "R7 out_valid", longint'(out_valid), longint'(m_fire));
    check(chop_pol == m_pol, "R3 chop_pol", longint'(chop_pol), longint'(m_pol));
    if (m_fire && out_valid) begin
      data_tag = m_chop ? "R4 chop data" : (m_ra ? "R5 avg data" : (m_af != 0 ? "R6 group data" : "R1 pass data"));
      check(longint'($signed(out_data)) == m_q, data_tag, longint'($signed(out_data)), m_q);
      if (m_first) begin
        check(m_words == m_k + int'(m_chop) + int'(m_chop || m_ra), "R8 settle words",
              m_words, m_k + int'(m_chop) + int'(m_chop || m_ra));
        m_first = 0;
      end
    end
  endtask

  function automatic longint gen(input int i, input int seed);
    if (i % 17 == 3) return 32767;
    if (i % 19 == 5) return -32768;
    return longint'(((i * 7919 + seed * 1237) % 65536)) - 32768;
  endfunction

  initial begin
    int wd;
    wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd >= WD_LIM) begin
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected=%0d", wd, WD_LIM);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    int afs[5];
    logic [15:0] w;
    afs = '{0, 1, 2, 5, 63};
    total = 0; bad = 0;
    rst_n = 0; cfg_wr = 0; cfg_data = '0; in_valid = 0; in_data = '0;
    m_clear(16'h0000); m_fire = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check(out_valid == 1'b0, "R1 reset out_valid", longint'(out_valid), 0);
    check(chop_pol == 1'b0, "R1 reset chop_pol", longint'(chop_pol), 0);
    for (int i = 0; i < 12; i++) step(1'b1, gen(i, 9), 1'b0, 16'h0);

    // sweep: R2 field decode with garbage in the low byte, written mid-stream
    for (int ch = 0; ch < 2; ch++)
      for (int ra = 0; ra < 2; ra++)
        for (int a = 0; a < 5; a++) begin
          w = {ch[0], ra[0], 6'(afs[a]), 8'(a * 53 + 17)};
          step(1'b0, 0, 1'b1, w);
          for (int i = 0; i < 150; i++)
            step((i % 5) != 4, gen(i, ch * 10 + ra * 5 + a), 1'b0, 16'h0);
        end

    // R9: word in the same cycle as a write is dropped
    step(1'b1, 1000, 1'b1, 16'h0000);
    step(1'b1, 77, 1'b0, 16'h0);
    check(longint'($signed(out_data)) == 77, "R9 dropped word", longint'($signed(out_data)), 77);
    step(1'b1, -500, 1'b1, 16'h8000);
    for (int i = 0; i < 10; i++) step(1'b1, gen(i, 3), 1'b0, 16'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule